// File: doc/BRIEF.md
# Gate Driver Command Qualification and Start-Up Control

This block is the digital control core of a single-channel gate driver. It takes two command inputs, one active-high and one active-low, and merges them into a single drive request. It also takes rail status flags and fault flags. It produces a gate-on command for the output stage and a companion flag that is high whenever the gate is off. Rail comparators, hysteresis and the analog output stage are outside the block. The block only consumes their digital results.

Drive is permitted only while the rails are valid and no fault is present. The positive rail must report good. The negative rail must report good unless a mode input says that rail is held at 0 V. Thermal shutdown and desaturation faults both block drive. When the rails first qualify, or requalify after a loss, the output does not follow a request that is already high. It waits for a fresh asserting edge of the merged request. This keeps a truncated pulse from reaching the gate. In non-inverting use that edge is a rising edge on the active-high input. In inverting use it is a falling edge on the active-low input.

All inputs pass through a parameterised synchronizer of `SYNC_STAGES` flops. Reset values of the synchronizer are safe: command idle, rails bad, faults present. The gate output is registered. An input change therefore reaches the outputs `SYNC_STAGES + 1` rising edges after it is applied.

Top module: `gd_ctrl_core`

## Requirements
- R1: Once started and qualified, `gate_on_o` is 1 only for `cmd_pos_i`=1 with `cmd_neg_i`=0. The other three combinations (00, 01, 11 as pos,neg) give 0.
- R2: During and after reset `gate_on_o`=0 and `gate_off_o`=1. An active request held through reset is not passed until it is released and asserted again.
- R3: Qualification requires `pos_rail_ok_i`=1, `neg_rail_ok_i`=1 (unless R4 applies), `therm_flt_i`=0 and `desat_flt_i`=0. With any of these not met, a fresh request edge leaves the gate off.
- R4: With `neg_rail_zero_i`=1 the negative-rail flag is ignored for qualification.
- R5: In non-inverting use (`cmd_neg_i`=0), switching starts at the first rising edge of `cmd_pos_i` seen after qualification. A request already high at qualification is not passed.
- R6: In inverting use (`cmd_pos_i`=1), switching starts at the first falling edge of `cmd_neg_i` seen after qualification. An on-period already in progress at qualification is not passed.
- R7: A request edge sampled in the same cycle that qualification first appears does not start switching. The edge must come strictly later.
- R8: Loss of any rail flag, or either fault, forces `gate_on_o` to 0 whatever the command inputs are.
- R9: Losing qualification clears the started state. After recovery the gate stays off until a new request edge arrives.
- R10: `gate_off_o` is always the complement of the actual `gate_on_o`. It is 1 during a forced turn-off even while the request is still high.
- R11: An input change is reflected at the outputs exactly `SYNC_STAGES + 1` rising clock edges after it is applied. At one edge fewer, the old value is still present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_pos_i | input | 1 | Active-high drive command |
| cmd_neg_i | input | 1 | Active-low drive command |
| pos_rail_ok_i | input | 1 | Positive supply above its turn-on threshold |
| neg_rail_ok_i | input | 1 | Negative rail past 80% of its programmed magnitude |
| neg_rail_zero_i | input | 1 | Negative rail configured as 0 V; skips its check |
| therm_flt_i | input | 1 | Thermal shutdown active |
| desat_flt_i | input | 1 | Desaturation fault active |
| gate_on_o | output | 1 | Gate drive command (1 = turn on) |
| gate_off_o | output | 1 | High whenever the gate is commanded off |

## Verification
Every result of this block is due `SYNC_STAGES + 1` rising edges after the input change that causes it. This holds for command-to-gate, fault-to-off and qualification-to-ready alike. The bench applies stimulus on falling edges and samples on the falling edge after exactly that many rising edges. For latency checks it also samples one edge earlier and expects the old value. Start-up cases need extra time for the qualification flag to settle before the request edge is applied. Those cases wait one extra cycle, so the edge lands strictly after qualification. A deliberately coincident case checks that such an edge is rejected.

// File: rtl/gd_pkg.sv
package gd_pkg;

    // Two command inputs as received from the controller side.
    typedef struct packed {
        logic pos;   // active-high request
        logic neg;   // active-low request
    } cmd_t;

    // Supply and protection status, one bit each.
    typedef struct packed {
        logic pos_ok;
        logic neg_ok;
        logic neg_zero;
        logic therm;
        logic desat;
    } rail_t;

    localparam int CMD_W  = $bits(cmd_t);
    localparam int RAIL_W = $bits(rail_t);

    // Safe values loaded at reset: command idle, rails bad, faults present.
    localparam cmd_t  CMD_IDLE  = '{pos: 1'b0, neg: 1'b1};
    localparam rail_t RAIL_SAFE = '{pos_ok: 1'b0, neg_ok: 1'b0, neg_zero: 1'b0,
                                    therm: 1'b1, desat: 1'b1};

    typedef enum logic [1:0] {
        ST_BLOCKED = 2'd0,  // not qualified, drive forbidden
        ST_WAIT    = 2'd1,  // qualified, waiting for a fresh request edge
        ST_ARMED   = 2'd2   // switching follows the request
    } arm_state_e;

    function automatic logic cmd_demand(cmd_t c);
        return c.pos & ~c.neg;
    endfunction

    function automatic logic rails_qualified(rail_t r);
        return r.pos_ok & (r.neg_ok | r.neg_zero) & ~r.therm & ~r.desat;
    endfunction

endpackage

// File: rtl/gd_sync.sv
module gd_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/gd_edge.sv
module gd_edge
    import gd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cmd_t cmd_i,
    output logic demand_o,
    output logic rise_o
);

    logic demand_d;

    assign demand_o = cmd_demand(cmd_i);

    // History starts high so that reset alone never looks like an edge.
    always_ff @(posedge clk) begin
        if (rst) demand_d <= 1'b1;
        else     demand_d <= demand_o;
    end

    assign rise_o = demand_o & ~demand_d;

endmodule

// File: rtl/gd_arm_fsm.sv
module gd_arm_fsm
    import gd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       qual_i,
    input  logic       demand_i,
    input  logic       rise_i,
    output arm_state_e state_o,
    output logic       gate_o
);

    arm_state_e state_q, state_nxt;
    logic       gate_nxt;

    always_comb begin
        state_nxt = state_q;
        if (!qual_i) begin
            state_nxt = ST_BLOCKED;
        end else begin
            unique case (state_q)
                ST_BLOCKED: state_nxt = ST_WAIT;
                ST_WAIT:    state_nxt = rise_i ? ST_ARMED : ST_WAIT;
                ST_ARMED:   state_nxt = ST_ARMED;
                default:    state_nxt = ST_BLOCKED;
            endcase
        end
    end

    always_comb begin
        gate_nxt = qual_i & demand_i &
                   ((state_q == ST_ARMED) | ((state_q == ST_WAIT) & rise_i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_BLOCKED;
            gate_o  <= 1'b0;
        end else begin
            state_q <= state_nxt;
            gate_o  <= gate_nxt;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/gd_ctrl_core.sv
module gd_ctrl_core
    import gd_pkg::*;
#(
    parameter int SYNC_STAGES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd_pos_i,
    input  logic cmd_neg_i,
    input  logic pos_rail_ok_i,
    input  logic neg_rail_ok_i,
    input  logic neg_rail_zero_i,
    input  logic therm_flt_i,
    input  logic desat_flt_i,
    output logic gate_on_o,
    output logic gate_off_o
);

    cmd_t       cmd_raw, cmd_s;
    rail_t      rail_raw, rail_s;
    logic       qual_s;
    logic       demand_s;
    logic       rise_s;
    arm_state_e state_s;

    assign cmd_raw  = '{pos: cmd_pos_i, neg: cmd_neg_i};
    assign rail_raw = '{pos_ok: pos_rail_ok_i, neg_ok: neg_rail_ok_i,
                        neg_zero: neg_rail_zero_i,
                        therm: therm_flt_i, desat: desat_flt_i};

    gd_sync #(
        .WIDTH  (CMD_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(CMD_IDLE)
    ) i_cmd_sync (
        .clk(clk),
        .rst(rst),
        .d_i(cmd_raw),
        .q_o(cmd_s)
    );

    gd_sync #(
        .WIDTH  (RAIL_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(RAIL_SAFE)
    ) i_rail_sync (
        .clk(clk),
        .rst(rst),
        .d_i(rail_raw),
        .q_o(rail_s)
    );

    assign qual_s = rails_qualified(rail_s);

    gd_edge i_edge (
        .clk     (clk),
        .rst     (rst),
        .cmd_i   (cmd_s),
        .demand_o(demand_s),
        .rise_o  (rise_s)
    );

    gd_arm_fsm i_fsm (
        .clk     (clk),
        .rst     (rst),
        .qual_i  (qual_s),
        .demand_i(demand_s),
        .rise_i  (rise_s),
        .state_o (state_s),
        .gate_o  (gate_on_o)
    );

    assign gate_off_o = ~gate_on_o;

endmodule

// File: rtl/gd_ctrl_core_chk.sv
module gd_ctrl_core_chk
    import gd_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       gate_on,
    input logic       demand,
    input logic       rise,
    input logic       qual,
    input arm_state_e state
);

    AST_GATE_NEEDS_DEMAND: assert property (@(posedge clk) disable iff (rst)
        gate_on |-> $past(demand));                                   // R1

    AST_UNQUALIFIED_FORCES_OFF: assert property (@(posedge clk) disable iff (rst)
        !qual |=> !gate_on);                                          // R8

    AST_TURN_ON_FROM_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_on) |-> $past(rise));                              // R5

    AST_BLOCKED_GATE_OFF: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BLOCKED) |-> !gate_on);                          // R9

    AST_ARM_ONLY_FROM_WAIT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARMED && $past(state) != ST_ARMED) |-> $past(state) == ST_WAIT); // R7

endmodule

bind gd_ctrl_core gd_ctrl_core_chk i_chk (
    .clk    (clk),
    .rst    (rst),
    .gate_on(gate_on_o),
    .demand (demand_s),
    .rise   (rise_s),
    .qual   (qual_s),
    .state  (state_s)
);

// File: tb/test_gd_ctrl_core.sv
module test_gd_ctrl_core;

    localparam int SYNC_STAGES = 1;
    localparam int LAT         = SYNC_STAGES + 1;

    logic clk = 1'b0;
    logic rst;
    logic cmd_pos, cmd_neg;
    logic pos_ok, neg_ok, neg_zero, therm, desat;
    logic gate_on, gate_off;

    int checks   = 0;
    int failures = 0;

    always #10 clk = ~clk;   // 50 MHz

    gd_ctrl_core #(.SYNC_STAGES(SYNC_STAGES)) i_gd_ctrl_core (
        .clk            (clk),
        .rst            (rst),
        .cmd_pos_i      (cmd_pos),
        .cmd_neg_i      (cmd_neg),
        .pos_rail_ok_i  (pos_ok),
        .neg_rail_ok_i  (neg_ok),
        .neg_rail_zero_i(neg_zero),
        .therm_flt_i    (therm),
        .desat_flt_i    (desat),
        .gate_on_o      (gate_on),
        .gate_off_o     (gate_off)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Every check also verifies the off flag against the gate (R10).
    task automatic chk(input string req, input logic exp_on);
        checks++;
        if (gate_on !== exp_on || gate_off !== ~exp_on) begin
            failures++;
            $display("FAIL %s: gate_on=%0b gate_off=%0b expected gate_on=%0b gate_off=%0b",
                     req, gate_on, gate_off, exp_on, ~exp_on);
        end
    endtask

    task automatic rails_good();
        pos_ok = 1'b1; neg_ok = 1'b1; neg_zero = 1'b0; therm = 1'b0; desat = 1'b0;
    endtask

    task automatic restart_pos();
        cmd_pos = 1'b0; step(LAT);
        cmd_pos = 1'b1; step(LAT);
    endtask

    initial begin
        rst = 1'b1;
        cmd_pos = 1'b1; cmd_neg = 1'b0;
        rails_good();
        step(3);
        chk("R2 in reset", 1'b0);
        rst = 1'b0;
        step(LAT + 3);
        chk("R2 held request after reset", 1'b0);

        // R5: release and reassert, with latency check (R11)
        cmd_pos = 1'b0; step(LAT);
        chk("R5 low request", 1'b0);
        cmd_pos = 1'b1; step(LAT - 1);
        chk("R11 one edge early", 1'b0);
        step(1);
        chk("R5 first rising edge", 1'b1);

        // R1 truth table while started: (pos,neg) = 00,01,10,11
        for (int i = 0; i < 4; i++) begin
            cmd_pos = i[1]; cmd_neg = i[0];
            step(LAT);
            chk("R1 truth table", i[1] & ~i[0]);
        end

        // R8 / R9: each protection source forces off and disarms
        for (int k = 0; k < 4; k++) begin
            cmd_pos = 1'b1; cmd_neg = 1'b0;
            step(LAT);
            chk("R1 running", 1'b1);
            case (k)
                0: therm  = 1'b1;
                1: desat  = 1'b1;
                2: pos_ok = 1'b0;
                default: neg_ok = 1'b0;
            endcase
            step(LAT - 1);
            chk("R11 fault one edge early", 1'b1);
            step(1);
            chk("R8 forced off", 1'b0);
            rails_good();
            step(LAT + 2);
            chk("R9 stays off after recovery", 1'b0);
            restart_pos();
            chk("R9 new edge restarts", 1'b1);
        end

        // R7: edge coincident with qualification is rejected
        pos_ok = 1'b0; cmd_pos = 1'b0; cmd_neg = 1'b0;
        step(LAT + 1);
        pos_ok = 1'b1; cmd_pos = 1'b1;
        step(LAT + 3);
        chk("R7 coincident edge", 1'b0);
        restart_pos();
        chk("R7 later edge", 1'b1);

        // R6: inverting use with cmd_pos held high
        pos_ok = 1'b0; cmd_pos = 1'b1; cmd_neg = 1'b1;
        step(LAT + 1);
        pos_ok = 1'b1;
        step(LAT + 1);
        chk("R6 idle", 1'b0);
        cmd_neg = 1'b0; step(LAT);
        chk("R6 falling edge starts", 1'b1);
        cmd_neg = 1'b1; step(LAT);
        chk("R6 off phase", 1'b0);
        cmd_neg = 1'b0; step(LAT);
        chk("R6 next on phase", 1'b1);

        // R6: on-period in progress at qualification is not passed
        pos_ok = 1'b0; step(LAT + 1);
        pos_ok = 1'b1; step(LAT + 2);
        chk("R6 partial pulse blocked", 1'b0);
        cmd_neg = 1'b1; step(LAT);
        cmd_neg = 1'b0; step(LAT);
        chk("R6 fresh falling edge", 1'b1);

        // R3 / R4: sweep all 32 rail and fault combinations
        cmd_neg = 1'b0;
        for (int r = 0; r < 32; r++) begin
            pos_ok = 1'b0; cmd_pos = 1'b0;
            step(LAT + 1);
            pos_ok = r[4]; neg_ok = r[3]; neg_zero = r[2]; therm = r[1]; desat = r[0];
            step(LAT + 1);
            cmd_pos = 1'b1;
            step(LAT);
            if (r[2])
                chk("R4 zero-rail mode", r[4] & ~r[1] & ~r[0]);
            else
                chk("R3 qualification", r[4] & r[3] & ~r[1] & ~r[0]);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule